// File: doc/BRIEF.md
# Front-End Port Condition and Status Register

This block is the 16-bit control and status register that a front-end processor reaches at a single address on its side of a host link. The front end writes it with paired set and clear bits, one pair per latched condition flag. There are five flags: the front-end interrupt, the host interrupt (a doorbell toward the host), nonexistent memory, parity error and word count overflow. The same write also loads an error interrupt enable, a front-end interrupt enable and a 3-bit interrupt level assignment.

The read image uses its own layout. It packs the five flags together, adds a read-only bit that shows whether the host has enabled this port, and then returns the enables and the assignment. The host can raise the front-end interrupt through a strobe. The transfer logic reports its errors through three strobes. The block drives a one-hot interrupt request vector toward the front end and a doorbell level toward the host.

Top module: `fe_port_csr`

## Requirements
- R1: After reset all five flags, both enables and the assignment are 0, so `rd_data` reads only the port-enabled bit, `irq_lvl` is 0 and `host_doorbell` is 0.
- R2: A write with `wr_en` high while the port is enabled sets or clears one flag per bit pair, with the set bit above the clear bit: 15/14 front-end interrupt, 13/12 host interrupt, 11/10 nonexistent memory, 9/8 parity error, 7/6 word count overflow.
- R3: When both bits of a pair are written as 1, the flag is set.
- R4: A pulse on `err_nxm`, `err_par` or `err_wco` sets its flag at the next clock edge, even when a write clears that flag in the same cycle, and even while the port is disabled.
- R5: A pulse on `host_set_fe` sets the front-end interrupt flag at the next clock edge, whether or not the port is enabled.
- R6: A write loads write bit 5 as the error interrupt enable, bit 4 as the front-end interrupt enable and bits 2:0 as the interrupt assignment. Bit 3 is ignored.
- R7: The read image is: bit 15 front-end interrupt, 14 host interrupt, 13 nonexistent memory, 12 parity error, 11 word count overflow, 10 port enabled (`port_en`), 5 error enable, 4 front-end enable, 2:0 assignment. All other bits read 0.
- R8: The internal request is (front-end interrupt flag AND front-end enable) OR (any of the three error flags AND error enable).
- R9: When the assignment is 0, `irq_lvl` is all zero. When the assignment is k in 1..7, `irq_lvl` equals the request on bit k-1, and every other bit is 0.
- R10: While `port_en` is low, front-end writes change no flag, enable or assignment.
- R11: `host_doorbell` follows the host interrupt flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_en | input | 1 | The host has enabled this port |
| wr_en | input | 1 | Front-end write strobe |
| wr_data | input | 16 | Front-end write image |
| rd_data | output | 16 | Read image (combinational from state) |
| host_set_fe | input | 1 | Host pulse that raises the front-end interrupt |
| err_nxm | input | 1 | Nonexistent-memory error pulse |
| err_par | input | 1 | Parity error pulse |
| err_wco | input | 1 | Word count overflow pulse |
| irq_lvl | output | 7 | One-hot interrupt request, bit k-1 for level k |
| host_doorbell | output | 1 | Interrupt level toward the host |

## Verification
Every state change caused by a write or a strobe lands on the first rising edge after the stimulus. `rd_data`, `irq_lvl` and `host_doorbell` are decoded combinationally from that state, so all of them are due one edge after the stimulus. The only exception is the port-enabled bit, which follows `port_en` with no delay. The bench drives each vector on a falling edge and compares on the next falling edge, before it drives the next vector, so every result is sampled exactly one edge after its cause.

// File: rtl/fe_csr_pkg.sv
package fe_csr_pkg;
  localparam int CSR_W      = 16;
  localparam int NFLAG      = 5;
  localparam int ASG_W      = 3;
  localparam int LVL_N      = (1 << ASG_W) - 1;
  // flag indices; also fix write-pair and read-bit positions
  localparam int F_WCO      = 0;
  localparam int F_PAR      = 1;
  localparam int F_NXM      = 2;
  localparam int F_HOST     = 3;
  localparam int F_FE       = 4;
  localparam int PAIR_LSB   = 6;   // clear bit of flag i at PAIR_LSB+2i, set bit one above
  localparam int FLG_RD_LSB = 11;  // flag i reads at FLG_RD_LSB+i
  localparam int PEN_BIT    = 10;
  localparam int ERR_EN_BIT = 5;
  localparam int FE_EN_BIT  = 4;

  // next value of a set/clear latched flag; set dominates
  function automatic logic pair_next(input logic q, input logic set, input logic clr);
    if (set)      return 1'b1;
    else if (clr) return 1'b0;
    else          return q;
  endfunction

  // request steering: level 0 mutes, level k drives bit k-1
  function automatic logic [LVL_N-1:0] lvl_decode(input logic req, input logic [ASG_W-1:0] asg);
    logic [LVL_N-1:0] v;
    v = '0;
    if (req && asg != '0) v = LVL_N'(1) << (asg - 1'b1);
    return v;
  endfunction
endpackage

// File: rtl/fe_csr_flags.sv
module fe_csr_flags #(
  parameter int NFLAG = fe_csr_pkg::NFLAG
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ok,
  input  logic [NFLAG-1:0] set_bits,
  input  logic [NFLAG-1:0] clr_bits,
  input  logic [NFLAG-1:0] hw_set,
  output logic [NFLAG-1:0] flags
);
  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    logic set_any;
    logic clr_any;
    assign set_any = hw_set[i] | (wr_ok & set_bits[i]);
    assign clr_any = wr_ok & clr_bits[i];
    always_ff @(posedge clk) begin
      if (!rst_n) flags[i] <= 1'b0;
      else        flags[i] <= fe_csr_pkg::pair_next(flags[i], set_any, clr_any);
    end
  end
endmodule

// File: rtl/fe_csr_cfg.sv
module fe_csr_cfg #(
  parameter int ASG_W = fe_csr_pkg::ASG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ok,
  input  logic             err_en_in,
  input  logic             fe_en_in,
  input  logic [ASG_W-1:0] asg_in,
  output logic             err_en,
  output logic             fe_en,
  output logic [ASG_W-1:0] asg
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_en <= 1'b0;
      fe_en  <= 1'b0;
      asg    <= '0;
    end else if (wr_ok) begin
      err_en <= err_en_in;
      fe_en  <= fe_en_in;
      asg    <= asg_in;
    end
  end
endmodule

// File: rtl/fe_csr_irq.sv
module fe_csr_irq #(
  parameter int ASG_W = fe_csr_pkg::ASG_W,
  parameter int LVL_N = (1 << ASG_W) - 1
) (
  input  logic             fe_flag,
  input  logic             fe_en,
  input  logic             err_any,
  input  logic             err_en,
  input  logic [ASG_W-1:0] asg,
  output logic             req_any,
  output logic [LVL_N-1:0] lvl
);
  assign req_any = (fe_flag & fe_en) | (err_any & err_en);
  assign lvl     = fe_csr_pkg::lvl_decode(req_any, asg);
endmodule

// File: rtl/fe_port_csr.sv
module fe_port_csr
  import fe_csr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             port_en,
  input  logic             wr_en,
  input  logic [CSR_W-1:0] wr_data,
  output logic [CSR_W-1:0] rd_data,
  input  logic             host_set_fe,
  input  logic             err_nxm,
  input  logic             err_par,
  input  logic             err_wco,
  output logic [LVL_N-1:0] irq_lvl,
  output logic             host_doorbell
);
  logic             wr_ok;
  logic [NFLAG-1:0] set_bits, clr_bits, hw_set, flags;
  logic             err_en, fe_en, err_any, req_any;
  logic [ASG_W-1:0] asg;
  logic             unused_wr_b3;

  assign wr_ok        = wr_en & port_en;
  assign unused_wr_b3 = wr_data[3];

  for (genvar i = 0; i < NFLAG; i++) begin : g_pair
    assign clr_bits[i] = wr_data[PAIR_LSB + 2*i];
    assign set_bits[i] = wr_data[PAIR_LSB + 2*i + 1];
  end

  always_comb begin
    hw_set         = '0;
    hw_set[F_FE]   = host_set_fe;
    hw_set[F_NXM]  = err_nxm;
    hw_set[F_PAR]  = err_par;
    hw_set[F_WCO]  = err_wco;
  end

  fe_csr_flags #(.NFLAG(NFLAG)) u_flags (
    .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok),
    .set_bits(set_bits), .clr_bits(clr_bits), .hw_set(hw_set), .flags(flags)
  );

  fe_csr_cfg #(.ASG_W(ASG_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok),
    .err_en_in(wr_data[ERR_EN_BIT]), .fe_en_in(wr_data[FE_EN_BIT]),
    .asg_in(wr_data[ASG_W-1:0]),
    .err_en(err_en), .fe_en(fe_en), .asg(asg)
  );

  assign err_any = flags[F_NXM] | flags[F_PAR] | flags[F_WCO];

  fe_csr_irq #(.ASG_W(ASG_W), .LVL_N(LVL_N)) u_irq (
    .fe_flag(flags[F_FE]), .fe_en(fe_en), .err_any(err_any), .err_en(err_en),
    .asg(asg), .req_any(req_any), .lvl(irq_lvl)
  );

  always_comb begin
    rd_data                               = '0;
    rd_data[FLG_RD_LSB +: NFLAG]          = flags;
    rd_data[PEN_BIT]                      = port_en;
    rd_data[ERR_EN_BIT]                   = err_en;
    rd_data[FE_EN_BIT]                    = fe_en;
    rd_data[ASG_W-1:0]                    = asg;
  end

  assign host_doorbell = flags[F_HOST];
endmodule

// File: rtl/fe_port_csr_chk.sv
module fe_port_csr_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        port_en,
  input logic        wr_en,
  input logic [15:12] wr_hi,
  input logic        host_set_fe,
  input logic        err_nxm,
  input logic        err_par,
  input logic        err_wco,
  input logic [15:0] rd_data,
  input logic [6:0]  irq_lvl,
  input logic        host_doorbell,
  input logic        req_any
);
  logic unused_pen_rd;
  assign unused_pen_rd = rd_data[10];

  p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en && wr_en && wr_hi[12] && !wr_hi[13]) |=> !rd_data[14]);
  p_set_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en && wr_en && wr_hi[15] && wr_hi[14]) |=> rd_data[15]);
  p_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    err_nxm |=> rd_data[13]);
  p_host_raise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    host_set_fe |=> rd_data[15]);
  p_req_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_lvl != 7'd0) |-> req_any);
  p_req_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_any && rd_data[2:0] != 3'd0) |-> (irq_lvl != 7'd0));
  p_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_lvl));
  p_mute_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[2:0] == 3'd0) |-> (irq_lvl == 7'd0));
  p_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!port_en && !host_set_fe && !err_nxm && !err_par && !err_wco)
      |=> ($stable(rd_data[15:11]) && $stable(rd_data[9:0])));
  p_bell_r11: assert property (@(posedge clk) disable iff (!rst_n)
    host_doorbell == rd_data[14]);
endmodule

bind fe_port_csr fe_port_csr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .port_en(port_en), .wr_en(wr_en),
  .wr_hi(wr_data[15:12]), .host_set_fe(host_set_fe),
  .err_nxm(err_nxm), .err_par(err_par), .err_wco(err_wco),
  .rd_data(rd_data), .irq_lvl(irq_lvl), .host_doorbell(host_doorbell),
  .req_any(req_any)
);

// File: tb/fe_port_csr_tb.sv
module fe_port_csr_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        port_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        host_set_fe = 1'b0;
  logic        err_nxm = 1'b0, err_par = 1'b0, err_wco = 1'b0;
  logic [15:0] rd_data;
  logic [6:0]  irq_lvl;
  logic        host_doorbell;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #4 clk = ~clk;  // 125 MHz

  fe_port_csr u_dut (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .host_set_fe(host_set_fe), .err_nxm(err_nxm),
    .err_par(err_par), .err_wco(err_wco), .irq_lvl(irq_lvl),
    .host_doorbell(host_doorbell)
  );

  // {port_en, wr_en, wr_data, host_set_fe, {nxm,par,wco}, exp_rd, exp_lvl, exp_bell}
  localparam int NV = 19;
  localparam logic [45:0] VEC [NV] = '{
    {1'b1,1'b1,16'h8000,1'b0,3'b000,16'h8400,7'h00,1'b0}, // R2 set fe
    {1'b1,1'b1,16'h0035,1'b0,3'b000,16'h8435,7'h10,1'b0}, // R6 R8 cfg, fe req lvl5
    {1'b1,1'b1,16'h4035,1'b0,3'b000,16'h0435,7'h00,1'b0}, // R2 clear fe
    {1'b1,1'b1,16'h2035,1'b0,3'b000,16'h4435,7'h00,1'b1}, // R11 set host
    {1'b1,1'b1,16'h1035,1'b0,3'b000,16'h0435,7'h00,1'b0}, // R2 clear host
    {1'b1,1'b0,16'h0000,1'b0,3'b100,16'h2435,7'h10,1'b0}, // R4 nxm strobe
    {1'b1,1'b1,16'h0C35,1'b0,3'b000,16'h2435,7'h10,1'b0}, // R3 set+clear
    {1'b1,1'b1,16'h0435,1'b0,3'b000,16'h0435,7'h00,1'b0}, // R2 clear nxm
    {1'b1,1'b1,16'h0135,1'b0,3'b010,16'h1435,7'h10,1'b0}, // R4 strobe beats clear
    {1'b1,1'b1,16'h0115,1'b0,3'b000,16'h0415,7'h00,1'b0}, // R8 err disabled
    {1'b1,1'b0,16'h0000,1'b0,3'b001,16'h0C15,7'h00,1'b0}, // R4 wco, R8 no req
    {1'b1,1'b1,16'h00A1,1'b0,3'b000,16'h0C21,7'h01,1'b0}, // R9 lvl1
    {1'b1,1'b1,16'h0067,1'b0,3'b000,16'h0427,7'h00,1'b0}, // R2 clear wco
    {1'b1,1'b0,16'h0000,1'b1,3'b000,16'h8427,7'h00,1'b0}, // R5 host raise, fe_en 0
    {1'b1,1'b1,16'h0037,1'b0,3'b000,16'h8437,7'h40,1'b0}, // R9 lvl7
    {1'b1,1'b1,16'h0030,1'b0,3'b000,16'h8430,7'h00,1'b0}, // R9 asg 0 mutes
    {1'b0,1'b1,16'h4037,1'b0,3'b000,16'h8030,7'h00,1'b0}, // R10 write ignored
    {1'b0,1'b0,16'h0000,1'b0,3'b001,16'h8830,7'h00,1'b0}, // R4 strobe while disabled
    {1'b1,1'b1,16'h4040,1'b0,3'b000,16'h0400,7'h00,1'b0}  // R7 back to idle
  };

  task automatic check(input string req, input logic [15:0] e_rd,
                       input logic [6:0] e_lvl, input logic e_bell);
    n_chk++;
    if (rd_data !== e_rd || irq_lvl !== e_lvl || host_doorbell !== e_bell) begin
      n_bad++;
      $display("FAIL %s: rd=%h lvl=%h bell=%b expected rd=%h lvl=%h bell=%b",
               req, rd_data, irq_lvl, host_doorbell, e_rd, e_lvl, e_bell);
    end
  endtask

  task automatic apply(input logic pe, input logic we, input logic [15:0] d,
                       input logic hs, input logic [2:0] er);
    @(negedge clk);
    port_en = pe; wr_en = we; wr_data = d; host_set_fe = hs;
    {err_nxm, err_par, err_wco} = er;
    @(negedge clk);
    wr_en = 1'b0; host_set_fe = 1'b0; {err_nxm, err_par, err_wco} = 3'b000;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: rd=%h expected run to end", rd_data);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    port_en = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset", 16'h0400, 7'h00, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", 16'h0400, 7'h00, 1'b0);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][45], VEC[i][44], VEC[i][43:28], VEC[i][27], VEC[i][26:24]);
      check($sformatf("R7 vector %0d", i), VEC[i][23:8], VEC[i][7:1], VEC[i][0]);
    end

    // R2 R3 every pair at once, R11 doorbell, R9 level 7
    apply(1'b1, 1'b1, 16'hAAB7, 1'b0, 3'b000);
    check("R2 all set", 16'hFC37, 7'h40, 1'b1);
    // R6 bit 3 ignored: writes 0x003F still reads asg 7
    apply(1'b1, 1'b1, 16'h003F, 1'b0, 3'b000);
    check("R6 bit3 ignored", 16'hFC37, 7'h40, 1'b1);
    // R10 disabled write of clear-all has no effect
    apply(1'b0, 1'b1, 16'h5540, 1'b0, 3'b000);
    check("R10 clear ignored", 16'hF837, 7'h40, 1'b1);
    apply(1'b1, 1'b1, 16'h5540, 1'b0, 3'b000);
    check("R2 all clear", 16'h0400, 7'h00, 1'b0);
    // R1 reset from a loaded state
    apply(1'b1, 1'b1, 16'hAAB3, 1'b0, 3'b000);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset clears", 16'h0400, 7'h00, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule